// File: doc/BRIEF.md
# SPI Master Controller with Byte FIFOs

This block is a register-mapped SPI master. Software reaches it over a simple 32-bit read/write port. It queues outgoing bytes in a 64-entry transmit FIFO and programs a byte count. It then sets a start bit. The shift engine clocks out exactly that many bytes in the selected clock polarity, phase and bit order. Each received byte is pushed into a 64-entry receive FIFO, and the start bit clears itself when the burst is done.

Bit timing comes from an external enable pulse, `sclk_tick`, supplied by a divider outside the block. Each pulse moves the serial clock by one half period. One of four active-low select lines is chosen by a field in the transfer register. That line is either driven by hardware for the length of the burst or held at a level set by software. FIFO levels and error events are gathered in an interrupt status register. Its event bits are cleared by writing 1. The interrupt pin is raised whenever an enabled status bit is set.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset the transfer register, FIFO counts and event bits read 0, all `spi_cs_n` lines are high, `spi_sclk` is 0 and `irq` is 0. The status register reads 0x32: bit 1 (RX empty), bit 4 (TX request) and bit 5 (TX empty) are set.
- R2: A write to 0x200 pushes bit field 7:0 into the TX FIFO. The FIFO status register at 0x1C shows the TX count in bits 23:16 and the RX count in bits 7:0. A push to a full TX FIFO (64 entries) is dropped and sets status bit 10.
- R3: Writing bit 31 of the transfer register (0x08) starts a burst of N bytes, where N is taken from 0x30. Bytes go out MSB first, or LSB first when bit 12 is set. With MISO looped back to MOSI, every byte sent is read back unchanged from 0x300.
- R4: Bit 1 (CPOL) sets the idle level of `spi_sclk`. Bit 0 (CPHA) chooses the sampling edge: 0 samples on the leading edge and 1 samples on the trailing edge. `spi_sclk` returns to its idle level after each burst.
- R5: When the TX FIFO is empty at a byte boundary inside a burst, the engine shifts out 0x00 and sets status bit 11.
- R6: When the last byte of a burst has been shifted, transfer register bit 31 reads 0 and status bit 12 is set.
- R7: Under hardware control (bit 6 = 0), the line selected by bits 5:4 is driven low from the start of the burst to its last clock edge, and high otherwise. A select line going from low to high sets status bit 13. At most one line is low at any time.
- R8: With bit 6 = 1, the selected line follows bit 7 of the transfer register, and every other line is high.
- R9: Writing 1 to a status bit in 13:8 clears it. The level bits 6:0 (0 RX count > RX trigger, 1 RX empty, 2 RX full, 4 TX count <= TX trigger, 5 TX empty, 6 TX full) follow the FIFOs and are not changed by writes.
- R10: `irq` is high exactly when some status bit is set and its bit in the enable register (0x10) is set.
- R11: Writing 1 to bit 31 (TX) or bit 15 (RX) of the FIFO control register (0x18) empties that FIFO. The bit then reads back 0.
- R12: A read of 0x300 with the RX FIFO empty returns the last byte popped and sets status bit 9. A received byte that arrives while the RX FIFO is full is dropped and sets bit 8.
- R13: When bit 7 of the global register (0x04) is set and the RX FIFO is full at a byte boundary, the engine waits with the select line held. It resumes once a byte is popped, and no byte is lost.
- R14: A burst starts only while bit 0 of 0x04 is set. Writing bit 31 of 0x04 empties both FIFOs, stops the engine, clears the start bit and the event bits, and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops RX FIFO at 0x300) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk_tick | input | 1 | Half-period enable for the serial clock |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low select lines |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never asserted together. They also assume that the clock mode and bit order stay unchanged while a burst is in flight, since the engine reads those fields live. The bench keeps to these limits. It issues one access at a time and rewrites the transfer register only after polling the start bit back to 0. It holds `sclk_tick` to a steady alternating pattern and loops MISO back to MOSI, so received data is known in advance.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W = 12;
    localparam int NUM_CS = 4;
    localparam int SEL_W  = $clog2(NUM_CS);

    localparam logic [ADDR_W-1:0] A_GLB  = 12'h004;
    localparam logic [ADDR_W-1:0] A_XFR  = 12'h008;
    localparam logic [ADDR_W-1:0] A_IEN  = 12'h010;
    localparam logic [ADDR_W-1:0] A_IST  = 12'h014;
    localparam logic [ADDR_W-1:0] A_FCT  = 12'h018;
    localparam logic [ADDR_W-1:0] A_FST  = 12'h01C;
    localparam logic [ADDR_W-1:0] A_BCNT = 12'h030;
    localparam logic [ADDR_W-1:0] A_TCNT = 12'h034;
    localparam logic [ADDR_W-1:0] A_BCTL = 12'h038;
    localparam logic [ADDR_W-1:0] A_TXD  = 12'h200;
    localparam logic [ADDR_W-1:0] A_RXD  = 12'h300;

    localparam int IRQ_W = 14;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_HOLD,
        ENG_FIN
    } eng_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             lvl;
        logic             own;
        logic             lsb;
        logic             cpol;
        logic             cpha;
    } xfer_cfg_t;

    typedef struct packed {
        logic cs_rise;
        logic done;
        logic tx_udr;
        logic tx_ovf;
        logic rx_udr;
        logic rx_ovf;
    } irq_evt_t;

    function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] k,
                                      input logic lsb);
        return lsb ? b[k] : b[3'd7 - k];
    endfunction

    function automatic logic [7:0] put_bit(input logic [7:0] b, input logic [2:0] k,
                                           input logic lsb, input logic v);
        logic [7:0] r;
        r = b;
        if (lsb) r[k] = v;
        else     r[3'd7 - k] = v;
        return r;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             go,
    input  xfer_cfg_t        cfg,
    input  logic             stop_full,
    input  logic [CNT_W-1:0] count,
    input  logic             tx_empty,
    input  logic [7:0]       tx_data,
    input  logic             rx_full,
    input  logic             miso,
    output logic             tx_pop,
    output logic             tx_udr,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi
);

    eng_state_e       st;
    logic [3:0]       half;
    logic [7:0]       txb, rxb, rx_fin, nb;
    logic [CNT_W-1:0] remain;
    logic             ph, mosi_q;
    logic [2:0]       idx;
    logic             run_tick, samp, byte_end, hold_now, advance, last, start, load;

    assign idx      = half[3:1];
    assign run_tick = (st == ENG_RUN) && tick;
    assign samp     = run_tick && (half[0] == cfg.cpha);
    assign rx_fin   = samp ? put_bit(rxb, idx, cfg.lsb, miso) : rxb;
    assign byte_end = run_tick && (half == 4'hF);
    assign hold_now = byte_end && stop_full && rx_full;
    assign advance  = (byte_end && !hold_now) || ((st == ENG_HOLD) && !rx_full);
    assign last     = (remain == CNT_W'(1));
    assign start    = (st == ENG_IDLE) && go && (count != '0);
    assign load     = start || (advance && !last);
    assign nb       = tx_empty ? 8'h00 : tx_data;

    assign tx_pop  = load && !tx_empty;
    assign tx_udr  = load && tx_empty;
    assign rx_push = advance;
    assign rx_data = (st == ENG_HOLD) ? rxb : rx_fin;
    assign busy    = (st == ENG_RUN) || (st == ENG_HOLD);
    assign done    = (st == ENG_FIN);
    assign sclk    = cfg.cpol ^ ph;
    assign mosi    = mosi_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st     <= ENG_IDLE;
            half   <= '0;
            txb    <= '0;
            rxb    <= '0;
            remain <= '0;
            ph     <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (go) begin
                        if (count == '0) begin
                            st <= ENG_FIN;
                        end else begin
                            txb    <= nb;
                            rxb    <= '0;
                            remain <= count;
                            half   <= '0;
                            ph     <= 1'b0;
                            if (!cfg.cpha) mosi_q <= pick_bit(nb, 3'd0, cfg.lsb);
                            st     <= ENG_RUN;
                        end
                    end
                end
                ENG_RUN: begin
                    if (tick) begin
                        ph   <= ~ph;
                        half <= half + 4'd1;
                        if (samp)
                            rxb <= rx_fin;
                        else if (!half[0])
                            mosi_q <= pick_bit(txb, idx, cfg.lsb);
                        else if (idx != 3'd7)
                            mosi_q <= pick_bit(txb, idx + 3'd1, cfg.lsb);
                        if (half == 4'hF) begin
                            if (hold_now) begin
                                st  <= ENG_HOLD;
                                rxb <= rx_fin;
                            end else if (last) begin
                                st <= ENG_FIN;
                            end else begin
                                remain <= remain - CNT_W'(1);
                                txb    <= nb;
                                rxb    <= '0;
                                if (!cfg.cpha) mosi_q <= pick_bit(nb, 3'd0, cfg.lsb);
                            end
                        end
                    end
                end
                ENG_HOLD: begin
                    if (!rx_full) begin
                        if (last) begin
                            st <= ENG_FIN;
                        end else begin
                            remain <= remain - CNT_W'(1);
                            txb    <= nb;
                            rxb    <= '0;
                            if (!cfg.cpha) mosi_q <= pick_bit(nb, 3'd0, cfg.lsb);
                            st     <= ENG_RUN;
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
    import spim_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 24,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                sclk_tick,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic [NUM_CS-1:0]   spi_cs_n,
    output logic                irq
);

    // configuration state
    logic             en, master, stop_full, srst_p;
    xfer_cfg_t        cfg;
    logic             xch;
    logic [IRQ_W-1:0] ien;
    irq_evt_t         evt, evt_now;
    logic [7:0]       tx_trig, rx_trig;
    logic             tx_rst_p, rx_rst_p;
    logic [CNT_W-1:0] bcnt, tcnt, bctl;
    logic [7:0]       rx_last;
    logic [NUM_CS-1:0] cs_prev;

    // FIFO and engine wiring
    logic          tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]    tx_dout, rx_dout, rx_din;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_push, rx_pop, rx_full, rx_empty;
    logic          eng_udr, eng_busy, eng_done, go;
    logic [6:0]    lvl;
    logic [31:0]   ist_word;

    wire wr_at = bus_wr;
    assign tx_push = wr_at && (bus_addr == A_TXD);
    assign rx_pop  = bus_rd && (bus_addr == A_RXD);
    assign go      = xch && en && !srst_p;

    spim_fifo #(.DW(8), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst(rst), .clr(tx_rst_p || srst_p),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.DW(8), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst(rst), .clr(rx_rst_p || srst_p),
        .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.CNT_W(CNT_W)) shift_i (
        .clk(clk), .rst(rst), .clr(srst_p), .tick(sclk_tick), .go(go),
        .cfg(cfg), .stop_full(stop_full), .count(bcnt),
        .tx_empty(tx_empty), .tx_data(tx_dout), .rx_full(rx_full), .miso(spi_miso),
        .tx_pop(tx_pop), .tx_udr(eng_udr), .rx_push(rx_push), .rx_data(rx_din),
        .busy(eng_busy), .done(eng_done), .sclk(spi_sclk), .mosi(spi_mosi)
    );

    // select line generation, one lane per line
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_comb begin
            if (cfg.sel == SEL_W'(g))
                spi_cs_n[g] = cfg.own ? cfg.lvl : ~eng_busy;
            else
                spi_cs_n[g] = 1'b1;
        end
    end

    // live FIFO level flags
    assign lvl = {tx_full, tx_empty, (8'(tx_cnt) <= tx_trig), 1'b0,
                  rx_full, rx_empty, (8'(rx_cnt) > rx_trig)};

    always_comb begin
        evt_now.rx_ovf  = rx_push && rx_full;
        evt_now.rx_udr  = rx_pop && rx_empty;
        evt_now.tx_ovf  = tx_push && tx_full;
        evt_now.tx_udr  = eng_udr;
        evt_now.done    = eng_done;
        evt_now.cs_rise = |(spi_cs_n & ~cs_prev);
    end

    assign ist_word = {18'd0, evt, 1'b0, lvl};
    assign irq      = |(ist_word[IRQ_W-1:0] & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            en        <= 1'b0;
            master    <= 1'b0;
            stop_full <= 1'b0;
            srst_p    <= 1'b0;
            cfg       <= '0;
            xch       <= 1'b0;
            ien       <= '0;
            evt       <= '0;
            tx_trig   <= '0;
            rx_trig   <= '0;
            tx_rst_p  <= 1'b0;
            rx_rst_p  <= 1'b0;
            bcnt      <= '0;
            tcnt      <= '0;
            bctl      <= '0;
            rx_last   <= '0;
            cs_prev   <= '1;
        end else begin
            cs_prev  <= spi_cs_n;
            tx_rst_p <= 1'b0;
            rx_rst_p <= 1'b0;
            srst_p   <= 1'b0;
            if (rx_pop && !rx_empty) rx_last <= rx_dout;
            if (eng_done) xch <= 1'b0;
            evt <= evt | evt_now;
            if (wr_at) begin
                case (bus_addr)
                    A_GLB: begin
                        en        <= bus_wdata[0];
                        master    <= bus_wdata[1];
                        stop_full <= bus_wdata[7];
                        srst_p    <= bus_wdata[31];
                    end
                    A_XFR: begin
                        cfg.cpha <= bus_wdata[0];
                        cfg.cpol <= bus_wdata[1];
                        cfg.sel  <= bus_wdata[4 +: SEL_W];
                        cfg.own  <= bus_wdata[6];
                        cfg.lvl  <= bus_wdata[7];
                        cfg.lsb  <= bus_wdata[12];
                        if (bus_wdata[31]) xch <= 1'b1;
                    end
                    A_IEN: ien <= bus_wdata[IRQ_W-1:0];
                    A_IST: evt <= (evt & ~irq_evt_t'(bus_wdata[13:8])) | evt_now;
                    A_FCT: begin
                        tx_rst_p <= bus_wdata[31];
                        tx_trig  <= bus_wdata[23:16];
                        rx_rst_p <= bus_wdata[15];
                        rx_trig  <= bus_wdata[7:0];
                    end
                    A_BCNT: bcnt <= bus_wdata[CNT_W-1:0];
                    A_TCNT: tcnt <= bus_wdata[CNT_W-1:0];
                    A_BCTL: bctl <= bus_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (srst_p) begin
                xch <= 1'b0;
                evt <= '0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_GLB:  bus_rdata = {srst_p, 23'd0, stop_full, 5'd0, master, en};
            A_XFR:  bus_rdata = {xch, 18'd0, cfg.lsb, 4'd0, cfg.lvl, cfg.own,
                                 2'(cfg.sel), 2'd0, cfg.cpol, cfg.cpha};
            A_IEN:  bus_rdata = 32'(ien);
            A_IST:  bus_rdata = ist_word;
            A_FCT:  bus_rdata = {tx_rst_p, 7'd0, tx_trig, rx_rst_p, 7'd0, rx_trig};
            A_FST:  bus_rdata = {8'd0, 8'(tx_cnt), 8'd0, 8'(rx_cnt)};
            A_BCNT: bus_rdata = 32'(bcnt);
            A_TCNT: bus_rdata = 32'(tcnt);
            A_BCTL: bus_rdata = 32'(bctl);
            A_RXD:  bus_rdata = {24'd0, rx_empty ? rx_last : rx_dout};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              eng_done,
    input logic              xch,
    input logic              tx_rst_p,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic [NUM_CS-1:0] spi_cs_n
);

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CW'(DEPTH));

    assert_rx_bound_R12: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH));

    assert_start_clear_R6: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !xch);

    assert_fifo_clear_R11: assert property (@(posedge clk) disable iff (rst)
        tx_rst_p |=> (tx_cnt == '0));

    assert_one_select_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(~spi_cs_n) <= 1);

endmodule

bind spi_master_ctl spim_checker #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .eng_done(eng_done), .xch(xch),
    .tx_rst_p(tx_rst_p), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_master_ctl_tb_top.sv
module spi_master_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_tick = 1'b0;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // bench-side copy of the clock mode used by the serial monitor
    logic       m_cpol = 1'b0, m_cpha = 1'b0, prev_sclk = 1'b0;
    logic [7:0] cap = '0;
    int         ncap = 0;

    localparam logic [11:0] GLB = 12'h004, XFR = 12'h008, IEN = 12'h010, IST = 12'h014,
                            FCT = 12'h018, FST = 12'h01C, BCNT = 12'h030,
                            TXD = 12'h200, RXD = 12'h300;

    // {lsb_first, cpol, cpha, data}
    localparam logic [10:0] VEC [8] = '{
        {3'b000, 8'hA5}, {3'b001, 8'h3C}, {3'b010, 8'h81}, {3'b011, 8'h7E},
        {3'b100, 8'hA5}, {3'b101, 8'h01}, {3'b110, 8'hC3}, {3'b111, 8'h5A}
    };

    assign spi_miso = spi_mosi;

    spi_master_ctl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_tick(sclk_tick),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        sclk_tick = ~sclk_tick;
    end

    // capture MOSI on the sampling edge the bench expects for the mode
    initial forever begin
        @(negedge clk);
        if (spi_sclk != prev_sclk) begin
            if ((prev_sclk == m_cpol) ^ m_cpha) begin
                cap  = {cap[6:0], spi_mosi};
                ncap = ncap + 1;
            end
        end
        prev_sclk = spi_sclk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FIAL-WATCHDOG expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int k = 0; k < 20000; k++) begin
            rd(XFR, v);
            if (!v[31]) break;
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int k = 0; k < 8; k++) rev8[k] = b[7-k];
    endfunction

    initial begin
        logic [31:0] v, tcr;
        logic [7:0]  exp_ser;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(XFR, v);  chk(v == 0, "R1 xfer reg", v, 0);
        rd(FST, v);  chk(v == 0, "R1 fifo counts", v, 0);
        rd(IST, v);  chk(v == 32'h32, "R1 status", v, 32'h32);
        chk(spi_cs_n == 4'hF && spi_sclk == 1'b0 && irq == 1'b0, "R1 pins",
            {spi_cs_n, spi_sclk, irq}, {4'hF, 2'b00});

        wr(GLB, 32'h3);

        // R3 / R4: table of modes and bit orders, looped back
        for (int n = 0; n < 8; n++) begin
            m_cpol = VEC[n][9];
            m_cpha = VEC[n][8];
            tcr = (32'(VEC[n][10]) << 12) | (32'd1 << 4) | (32'(VEC[n][9]) << 1)
                  | 32'(VEC[n][8]);
            wr(XFR, tcr);
            wr(TXD, 32'(VEC[n][7:0]));
            wr(BCNT, 32'd1);
            ncap = 0; cap = '0;
            wr(XFR, tcr | 32'h8000_0000);
            if (n == 0) begin
                repeat (3) @(negedge clk);
                chk(spi_cs_n == 4'b1101, "R7 select low in burst", spi_cs_n, 4'b1101);
            end
            wait_done();
            exp_ser = VEC[n][10] ? rev8(VEC[n][7:0]) : VEC[n][7:0];
            chk(ncap == 8 && cap == exp_ser, "R3 serial order", cap, exp_ser);
            chk(spi_sclk == VEC[n][9], "R4 idle level", spi_sclk, VEC[n][9]);
            rd(RXD, v);
            chk(v[7:0] == VEC[n][7:0], "R3 loopback byte", v, VEC[n][7:0]);
            if (n == 0) begin
                rd(IST, v);
                chk(v[12] == 1'b1, "R6 complete flag", v, 32'h1000);
                chk(v[13] == 1'b1 && spi_cs_n == 4'hF, "R7 select released", v, 32'h2000);
            end
        end

        // R12: empty read returns last byte
        rd(RXD, v);
        chk(v[7:0] == 8'h5A, "R12 underrun data", v, 8'h5A);
        rd(IST, v);
        chk(v[9] == 1'b1, "R12 underrun flag", v, 32'h200);

        // R9 / R10: write-one-to-clear and interrupt gating
        wr(IST, 32'h1000 | 32'h20);
        rd(IST, v);
        chk(v[12] == 1'b0 && v[13] == 1'b1 && v[5] == 1'b1, "R9 w1c", v, 32'h2000);
        wr(IEN, 32'h2000);
        @(negedge clk);
        chk(irq == 1'b1, "R10 irq set", irq, 1);
        wr(IST, 32'h2000);
        chk(irq == 1'b0, "R10 irq cleared", irq, 0);
        wr(IEN, 32'h20);
        chk(irq == 1'b1, "R10 level source", irq, 1);
        wr(IEN, 32'h0);

        // R5: TX FIFO runs dry mid-burst
        m_cpol = 0; m_cpha = 0;
        wr(XFR, 32'h10);
        wr(IST, 32'h3F00);
        wr(TXD, 32'hA5); wr(TXD, 32'h3C); wr(TXD, 32'h0F);
        wr(BCNT, 32'd5);
        wr(XFR, 32'h8000_0010);
        wait_done();
        rd(IST, v);
        chk(v[11] == 1'b1, "R5 underrun flag", v, 32'h800);
        rd(RXD, v); chk(v[7:0] == 8'hA5, "R5 byte0", v, 8'hA5);
        rd(RXD, v); chk(v[7:0] == 8'h3C, "R5 byte1", v, 8'h3C);
        rd(RXD, v); chk(v[7:0] == 8'h0F, "R5 byte2", v, 8'h0F);
        rd(RXD, v); chk(v[7:0] == 8'h00, "R5 pad byte3", v, 0);
        rd(RXD, v); chk(v[7:0] == 8'h00, "R5 pad byte4", v, 0);

        // R2 / R11: overflow of TX FIFO then self-clearing reset
        for (int k = 0; k < 65; k++) wr(TXD, 32'(k));
        rd(FST, v);
        chk(v[23:16] == 8'd64, "R2 tx count", v[23:16], 64);
        rd(IST, v);
        chk(v[10] == 1'b1 && v[6] == 1'b1, "R2 overflow flag", v, 32'h440);
        wr(FCT, 32'h8000_0000);
        rd(FCT, v);
        chk(v[31] == 1'b0, "R11 reset bit reads 0", v, 0);
        rd(FST, v);
        chk(v[23:16] == 8'd0, "R11 tx emptied", v, 0);

        // R8: software-owned select
        wr(XFR, 32'h60);
        chk(spi_cs_n == 4'b1011, "R8 sw low", spi_cs_n, 4'b1011);
        wr(XFR, 32'hE0);
        chk(spi_cs_n == 4'b1111, "R8 sw high", spi_cs_n, 4'b1111);

        // R13: stop on full RX FIFO
        wr(XFR, 32'h10);
        wr(FCT, 32'h8000_8000);
        wr(IST, 32'h3F00);
        wr(GLB, 32'h83);
        wr(BCNT, 32'd65);
        wr(XFR, 32'h8000_0010);
        repeat (65 * 32 + 300) @(negedge clk);
        rd(XFR, v);
        chk(v[31] == 1'b1, "R13 engine holds", v, 32'h8000_0000);
        chk(spi_cs_n[1] == 1'b0, "R13 select held", spi_cs_n, 4'b1101);
        rd(RXD, v);
        wait_done();
        rd(FST, v);
        chk(v[7:0] == 8'd64, "R13 rx count", v[7:0], 64);
        rd(IST, v);
        chk(v[8] == 1'b0, "R13 no loss", v, 0);

        // R12: overrun without stop
        wr(GLB, 32'h3);
        wr(BCNT, 32'd65);
        wr(XFR, 32'h8000_0010);
        wait_done();
        rd(IST, v);
        chk(v[8] == 1'b1, "R12 overrun flag", v, 32'h100);
        rd(FST, v);
        chk(v[7:0] == 8'd64, "R12 rx count", v[7:0], 64);

        // R14: enable gating and soft reset
        wr(GLB, 32'h0);
        wr(FCT, 32'h8000_8000);
        wr(TXD, 32'h11);
        wr(XFR, 32'h8000_0010);
        repeat (100) @(negedge clk);
        chk(spi_cs_n == 4'hF, "R14 no start when disabled", spi_cs_n, 4'hF);
        rd(FST, v);
        chk(v[23:16] == 8'd1, "R14 tx untouched", v[23:16], 1);
        wr(GLB, 32'h8000_0000);
        rd(XFR, v);
        chk(v[31] == 1'b0, "R14 start cleared", v, 0);
        rd(FST, v);
        chk(v == 0, "R14 fifos emptied", v, 0);
        rd(IST, v);
        chk((v & 32'h3F00) == 0, "R14 events cleared", v, 0);
        rd(GLB, v);
        chk(v[31] == 1'b0, "R14 reset bit reads 0", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule